// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the processor-facing register front end of a three-channel interval timer. A two-bit address selects one of four byte ports: ports 0 to 2 are the data ports of channels 0 to 2, and port 3 takes control words. Control words set the counting mode, the BCD flag and the byte access pattern of each channel. They also carry the command that freezes a counter value for later readout. Data port writes are gathered into 16-bit initial counts. Each completed count is presented to the counting datapath together with a one-cycle commit pulse for that channel.

The counting datapath lies outside this block. It supplies the live value of each counter. A read of a data port returns one byte in the same cycle. That byte comes from the frozen copy when one is pending, and from the live counter otherwise. In two-byte access the low byte comes first. Each channel keeps its own write byte pointer, read byte pointer and latch-pending flag. These advance only on strobes addressed to that channel.

Top module: `timer_host_regs`

## Requirements
- R1: A control word (wdata bits 7:6 = channel 0..2, bits 5:4 = access code, bits 3:1 = counting mode, bit 0 = BCD) with a nonzero access code stores the mode, BCD flag and access code of that channel. These appear on ch_mode/ch_bcd after the write edge. The channel's write byte pointer and partial byte are cleared.
- R2: A control word with channel field 11 changes no output and no channel state.
- R3: With access code 11, the first data write supplies the low byte and the second the high byte. The count appears on ch_count together with a one-cycle count_commit pulse in the cycle after the second write. count_commit never has more than one bit set, and ch_count changes only with a commit.
- R4: With access code 01, a single data write commits {8'h00, byte}. With access code 10, a single data write commits {byte, 8'h00}. Control-port writes never produce a commit.
- R5: A control word that arrives between the two bytes of a two-byte count drops the pending low byte. The next data write is taken as a low byte again.
- R6: A control word with access code 00 copies that channel's live counter at the write edge into a latch and sets latch-pending. While latch-pending is set, reads return the latched value whatever the live counter does.
- R7: A latch command for a channel whose latch is still pending has no effect.
- R8: In two-byte access, reads alternate low byte then high byte. A latch command restarts the order at the low byte. Reading the high byte clears latch-pending, and later reads return the live value.
- R9: With access code 01 or 10, each read returns the low or high byte of the source, and a single read clears latch-pending.
- R10: Committing a new count clears that channel's latch-pending flag.
- R11: rdata is valid in the same cycle as rd_en. It is zero for the control port and when rd_en is low. Reads and writes move only the pointers of the addressed channel.
- R12: After reset every channel has mode 3, BCD 0, access code 11, count 0, both byte pointers at the low byte, no pending latch and no commit.
- R13: A read and a write of the same data port in one cycle return the byte selected by the state before the edge. Both byte pointers advance, and a commit in that cycle drops the pending latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Port select: 0..2 channel data, 3 control |
| wdata | input | 8 | Write byte |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read byte, same cycle as rd_en |
| live_count | input | 48 | Live counter values from the datapath, channel n at bits 16n+15:16n |
| ch_mode | output | 9 | Counting mode per channel, 3 bits each |
| ch_bcd | output | 3 | BCD flag per channel |
| ch_count | output | 48 | Committed initial count per channel |
| count_commit | output | 3 | One-cycle pulse per channel when a new count is committed |

## Verification
The bus carries a single address, so only one pair of functions can meet in one cycle: a readback and a count commit on the same data port. The bench provokes this in a directed case. It sets a latch, writes the first count byte, and then asserts read and write together on that port with the second byte. It checks three things: the returned byte is the latched low byte, the count commits, and the following read gives the live high byte because the commit dropped the latch. Random mixes of simultaneous read and write strobes against the bench's reference model cover the same collision in every access pattern.

// File: rtl/timer_host_pkg.sv
package timer_host_pkg;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned CNT_W    = 2 * BYTE_W;
    localparam int unsigned MODE_W   = 3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_LOHI  = 2'b11
    } acc_e;

    typedef struct packed {
        logic [1:0]        sel;
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } ctl_word_t;
endpackage

// File: rtl/timer_ctl_decode.sv
module timer_ctl_decode
    import timer_host_pkg::*;
#(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned ADDR_W = 2
) (
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BYTE_W-1:0]  wdata,
    output logic [NUM_CH-1:0]  cfg_we,
    output logic [NUM_CH-1:0]  latch_cmd,
    output logic [NUM_CH-1:0]  data_we,
    output logic [NUM_CH-1:0]  data_re,
    output acc_e               cfg_acc,
    output logic [MODE_W-1:0]  cfg_mode,
    output logic               cfg_bcd
);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_CH);

    ctl_word_t cw;
    logic      ctl_wr;

    assign cw       = ctl_word_t'(wdata);
    assign ctl_wr   = wr_en && (addr == CTL_ADDR);
    assign cfg_acc  = cw.acc;
    assign cfg_mode = cw.mode;
    assign cfg_bcd  = cw.bcd;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
        logic hit;
        assign hit          = ctl_wr && (cw.sel == 2'(g));
        assign cfg_we[g]    = hit && (cw.acc != ACC_LATCH);
        assign latch_cmd[g] = hit && (cw.acc == ACC_LATCH);
        assign data_we[g]   = wr_en && (addr == ADDR_W'(g));
        assign data_re[g]   = rd_en && (addr == ADDR_W'(g));
    end
endmodule

// File: rtl/timer_chan_regs.sv
module timer_chan_regs
    import timer_host_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               latch_cmd,
    input  logic               data_we,
    input  logic               data_re,
    input  acc_e               cfg_acc,
    input  logic [MODE_W-1:0]  cfg_mode,
    input  logic               cfg_bcd,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic [CNT_W-1:0]   live_cnt,
    output logic [MODE_W-1:0]  mode,
    output logic               bcd,
    output logic [CNT_W-1:0]   count,
    output logic               commit,
    output logic [BYTE_W-1:0]  rd_byte
);
    typedef struct packed {
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
        logic              wr_hi;
        logic [BYTE_W-1:0] part;
        logic [CNT_W-1:0]  cnt;
        logic              commit;
        logic              rd_hi;
        logic              full;
        logic [CNT_W-1:0]  held;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic [CNT_W-1:0] src;

    // Read source and byte selection use the state before the edge
    always_comb begin
        src = st_q.full ? st_q.held : live_cnt;
        unique case (st_q.acc)
            ACC_HI:   rd_byte = src[CNT_W-1:BYTE_W];
            ACC_LOHI: rd_byte = st_q.rd_hi ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
            default:  rd_byte = src[BYTE_W-1:0];
        endcase
    end

    always_comb begin
        st_d        = st_q;
        st_d.commit = 1'b0;

        if (data_re) begin
            if (st_q.acc == ACC_LOHI) begin
                st_d.rd_hi = ~st_q.rd_hi;
                if (st_q.rd_hi) st_d.full = 1'b0;
            end else begin
                st_d.full = 1'b0;
            end
        end

        if (data_we) begin
            unique case (st_q.acc)
                ACC_LO: begin
                    st_d.cnt    = {{BYTE_W{1'b0}}, wdata};
                    st_d.commit = 1'b1;
                end
                ACC_HI: begin
                    st_d.cnt    = {wdata, {BYTE_W{1'b0}}};
                    st_d.commit = 1'b1;
                end
                ACC_LOHI: begin
                    if (!st_q.wr_hi) begin
                        st_d.part  = wdata;
                        st_d.wr_hi = 1'b1;
                    end else begin
                        st_d.cnt    = {wdata, st_q.part};
                        st_d.wr_hi  = 1'b0;
                        st_d.commit = 1'b1;
                    end
                end
                default: ;
            endcase
            if (st_d.commit) st_d.full = 1'b0;
        end

        if (cfg_we) begin
            st_d.acc   = cfg_acc;
            st_d.mode  = cfg_mode;
            st_d.bcd   = cfg_bcd;
            st_d.wr_hi = 1'b0;
            st_d.part  = '0;
        end

        if (latch_cmd && !st_q.full) begin
            st_d.held  = live_cnt;
            st_d.full  = 1'b1;
            st_d.rd_hi = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.acc    <= ACC_LOHI;
            st_q.mode   <= MODE_W'(3);
            st_q.bcd    <= 1'b0;
            st_q.wr_hi  <= 1'b0;
            st_q.part   <= '0;
            st_q.cnt    <= '0;
            st_q.commit <= 1'b0;
            st_q.rd_hi  <= 1'b0;
            st_q.full   <= 1'b0;
            st_q.held   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode   = st_q.mode;
    assign bcd    = st_q.bcd;
    assign count  = st_q.cnt;
    assign commit = st_q.commit;
endmodule

// File: rtl/timer_host_regs.sv
module timer_host_regs
    import timer_host_pkg::*;
#(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned ADDR_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [BYTE_W-1:0]        wdata,
    input  logic                     wr_en,
    input  logic                     rd_en,
    output logic [BYTE_W-1:0]        rdata,
    input  logic [NUM_CH*CNT_W-1:0]  live_count,
    output logic [NUM_CH*MODE_W-1:0] ch_mode,
    output logic [NUM_CH-1:0]        ch_bcd,
    output logic [NUM_CH*CNT_W-1:0]  ch_count,
    output logic [NUM_CH-1:0]        count_commit
);
    logic [NUM_CH-1:0] cfg_we, latch_cmd, data_we, data_re;
    acc_e              cfg_acc;
    logic [MODE_W-1:0] cfg_mode;
    logic              cfg_bcd;
    logic [BYTE_W-1:0] rd_bytes [NUM_CH];

    timer_ctl_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dec_i (
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .cfg_we    (cfg_we),
        .latch_cmd (latch_cmd),
        .data_we   (data_we),
        .data_re   (data_re),
        .cfg_acc   (cfg_acc),
        .cfg_mode  (cfg_mode),
        .cfg_bcd   (cfg_bcd)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        timer_chan_regs chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (cfg_we[g]),
            .latch_cmd (latch_cmd[g]),
            .data_we   (data_we[g]),
            .data_re   (data_re[g]),
            .cfg_acc   (cfg_acc),
            .cfg_mode  (cfg_mode),
            .cfg_bcd   (cfg_bcd),
            .wdata     (wdata),
            .live_cnt  (live_count[g*CNT_W +: CNT_W]),
            .mode      (ch_mode[g*MODE_W +: MODE_W]),
            .bcd       (ch_bcd[g]),
            .count     (ch_count[g*CNT_W +: CNT_W]),
            .commit    (count_commit[g]),
            .rd_byte   (rd_bytes[g])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (data_re[i]) rdata = rd_bytes[i];
        end
    end
endmodule

// File: rtl/timer_host_regs_chk.sv
module timer_host_regs_chk
    import timer_host_pkg::*;
#(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned ADDR_W = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [ADDR_W-1:0]        addr,
    input logic [BYTE_W-1:0]        wdata,
    input logic                     wr_en,
    input logic                     rd_en,
    input logic [BYTE_W-1:0]        rdata,
    input logic [NUM_CH*MODE_W-1:0] ch_mode,
    input logic [NUM_CH-1:0]        ch_bcd,
    input logic [NUM_CH*CNT_W-1:0]  ch_count,
    input logic [NUM_CH-1:0]        count_commit
);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_CH);

    assert_commit_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(count_commit));

    assert_count_needs_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_count != $past(ch_count)) |-> (|count_commit));

    assert_commit_from_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|count_commit) |-> ($past(wr_en) && ($past(addr) != CTL_ADDR)));

    assert_cfg_only_by_ctl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en && (addr == CTL_ADDR)) |-> ($stable(ch_mode) && $stable(ch_bcd)));

    assert_sel3_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && (addr == CTL_ADDR) && (wdata[7:6] == 2'b11))
        |-> ($stable(ch_mode) && $stable(ch_bcd) && (count_commit == '0)));

    assert_ctl_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == CTL_ADDR)) |-> (rdata == '0));
endmodule

bind timer_host_regs timer_host_regs_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr         (addr),
    .wdata        (wdata),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .rdata        (rdata),
    .ch_mode      (ch_mode),
    .ch_bcd       (ch_bcd),
    .ch_count     (ch_count),
    .count_commit (count_commit)
);

// File: tb/timer_host_regs_tb_top.sv
`timescale 1ns/1ps
module timer_host_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic [47:0] live_count = '0;
    logic [8:0]  ch_mode;
    logic [2:0]  ch_bcd;
    logic [47:0] ch_count;
    logic [2:0]  count_commit;

    int n_chk = 0;
    int n_err = 0;

    // reference model
    logic [1:0]  m_acc [3];
    logic [2:0]  m_mode [3];
    logic        m_bcd [3], m_whi [3], m_rhi [3], m_full [3];
    logic [7:0]  m_part [3];
    logic [15:0] m_cnt [3], m_lat [3];
    logic [2:0]  m_commit;
    logic [7:0]  last_rd;

    always #5 clk = ~clk;

    timer_host_regs dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .live_count(live_count), .ch_mode(ch_mode),
        .ch_bcd(ch_bcd), .ch_count(ch_count), .count_commit(count_commit)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int ch);
        logic [15:0] s;
        s = m_full[ch] ? m_lat[ch] : live_count[ch*16 +: 16];
        if (m_acc[ch] == 2'b10) return s[15:8];
        if (m_acc[ch] == 2'b11) return m_rhi[ch] ? s[15:8] : s[7:0];
        return s[7:0];
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 3; c++) begin
            m_acc[c] = 2'b11; m_mode[c] = 3'd3; m_bcd[c] = 0; m_whi[c] = 0;
            m_rhi[c] = 0; m_full[c] = 0; m_part[c] = 0; m_cnt[c] = 0; m_lat[c] = 0;
        end
        m_commit = 0;
    endtask

    task automatic bus(input logic w, input logic r, input logic [1:0] a, input logic [7:0] d,
                       input logic [47:0] lv, input string req);
        int c;
        @(negedge clk);
        live_count = lv; wr_en = w; rd_en = r; addr = a; wdata = d;
        #1;
        last_rd = rdata;
        if (r) chk(rdata, (a == 2'd3) ? 8'h00 : exp_byte(int'(a)), req, "rdata");
        m_commit = 0;
        if (r && a != 2'd3) begin
            c = int'(a);
            if (m_acc[c] == 2'b11) begin
                if (m_rhi[c]) m_full[c] = 0;
                m_rhi[c] = ~m_rhi[c];
            end else m_full[c] = 0;
        end
        if (w && a != 2'd3) begin
            c = int'(a);
            case (m_acc[c])
                2'b01: begin m_cnt[c] = {8'h00, d}; m_commit[c] = 1; end
                2'b10: begin m_cnt[c] = {d, 8'h00}; m_commit[c] = 1; end
                2'b11: if (!m_whi[c]) begin m_part[c] = d; m_whi[c] = 1; end
                       else begin m_cnt[c] = {d, m_part[c]}; m_whi[c] = 0; m_commit[c] = 1; end
                default: ;
            endcase
            if (m_commit[c]) m_full[c] = 0;
        end
        if (w && a == 2'd3 && d[7:6] != 2'b11) begin
            c = int'(d[7:6]);
            if (d[5:4] == 2'b00) begin
                if (!m_full[c]) begin m_lat[c] = lv[c*16 +: 16]; m_full[c] = 1; m_rhi[c] = 0; end
            end else begin
                m_acc[c] = d[5:4]; m_mode[c] = d[3:1]; m_bcd[c] = d[0]; m_whi[c] = 0; m_part[c] = 0;
            end
        end
        @(posedge clk);
        #1;
        wr_en = 0; rd_en = 0;
        chk(count_commit, m_commit, req, "count_commit");
        for (int k = 0; k < 3; k++) begin
            chk(ch_count[k*16 +: 16], m_cnt[k], req, "ch_count");
            chk(ch_mode[k*3 +: 3], m_mode[k], req, "ch_mode");
            chk(ch_bcd[k], m_bcd[k], req, "ch_bcd");
        end
    endtask

    function automatic logic [47:0] rnd48();
        return 48'({$urandom(), $urandom()});
    endfunction

    initial begin
        #(200000 * 10);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5eed1234);
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R12 reset state
        chk(ch_mode, {3'd3, 3'd3, 3'd3}, "R12", "mode after reset");
        chk(ch_count, 48'h0, "R12", "count after reset");
        chk(count_commit, 3'b000, "R12", "commit after reset");
        chk(ch_bcd, 3'b000, "R12", "bcd after reset");
        rst_n = 1'b1;
        bus(0, 1, 2'd0, 8'h00, 48'h0000_0000_A55A, "R12");
        chk(last_rd, 8'h5A, "R12", "first read low byte");

        // R1 / R3 two-byte count
        bus(1, 0, 2'd3, 8'h36, rnd48(), "R1");
        chk(ch_mode[2:0], 3'd3, "R1", "ch0 mode");
        bus(1, 0, 2'd0, 8'h34, rnd48(), "R3");
        chk(count_commit, 3'b000, "R3", "no commit after low byte");
        bus(1, 0, 2'd0, 8'h12, rnd48(), "R3");
        chk(ch_count[15:0], 16'h1234, "R3", "two-byte count");

        // R4 single-byte counts
        bus(1, 0, 2'd3, 8'h50, rnd48(), "R4");
        bus(1, 0, 2'd1, 8'h5A, rnd48(), "R4");
        chk(ch_count[31:16], 16'h005A, "R4", "low-only count");
        bus(1, 0, 2'd3, 8'hA5, rnd48(), "R1");
        chk(ch_bcd[2], 1'b1, "R1", "ch2 bcd");
        chk(ch_mode[8:6], 3'd2, "R1", "ch2 mode");
        bus(1, 0, 2'd2, 8'h77, rnd48(), "R4");
        chk(ch_count[47:32], 16'h7700, "R4", "high-only count");

        // R5 control word drops a pending low byte
        bus(1, 0, 2'd3, 8'h30, rnd48(), "R5");
        bus(1, 0, 2'd0, 8'hAA, rnd48(), "R5");
        bus(1, 0, 2'd3, 8'h30, rnd48(), "R5");
        bus(1, 0, 2'd0, 8'hBB, rnd48(), "R5");
        bus(1, 0, 2'd0, 8'hCC, rnd48(), "R5");
        chk(ch_count[15:0], 16'hCCBB, "R5", "restarted count");

        // R2 channel field 11 ignored
        bus(1, 0, 2'd3, 8'hFE, rnd48(), "R2");
        chk(ch_mode, {3'd2, 3'd0, 3'd0}, "R2", "modes unchanged");

        // R6 R7 R8 latch and two-byte readback
        bus(1, 0, 2'd3, 8'h00, 48'h0000_0000_BEEF, "R6");
        bus(0, 1, 2'd0, 8'h00, 48'h0000_0000_1357, "R6");
        chk(last_rd, 8'hEF, "R6", "latched low byte");
        bus(1, 0, 2'd3, 8'h00, 48'h0000_0000_1111, "R7");
        bus(0, 1, 2'd0, 8'h00, 48'h0000_0000_2468, "R7");
        chk(last_rd, 8'hBE, "R7", "second latch ignored");
        bus(0, 1, 2'd0, 8'h00, 48'h0000_0000_9A3C, "R8");
        chk(last_rd, 8'h3C, "R8", "live after high byte");

        // R9 single-byte readback clears latch
        bus(1, 0, 2'd3, 8'h40, 48'h0000_4321_0000, "R9");
        bus(0, 1, 2'd1, 8'h00, 48'h0000_8765_0000, "R9");
        chk(last_rd, 8'h21, "R9", "latched low-only");
        bus(0, 1, 2'd1, 8'h00, 48'h0000_8765_0000, "R9");
        chk(last_rd, 8'h65, "R9", "live after single read");

        // R10 commit drops latch
        bus(1, 0, 2'd3, 8'h80, 48'h9876_0000_0000, "R10");
        bus(1, 0, 2'd2, 8'h11, 48'h5432_0000_0000, "R10");
        bus(0, 1, 2'd2, 8'h00, 48'h5432_0000_0000, "R10");
        chk(last_rd, 8'h54, "R10", "live high after commit");

        // R13 read and commit in the same cycle
        bus(1, 0, 2'd3, 8'h30, rnd48(), "R13");
        bus(1, 0, 2'd0, 8'h01, rnd48(), "R13");
        bus(1, 0, 2'd3, 8'h00, 48'h0000_0000_CAFE, "R13");
        bus(1, 1, 2'd0, 8'h02, 48'h0000_0000_7788, "R13");
        chk(last_rd, 8'hFE, "R13", "pre-edge latched byte");
        chk(ch_count[15:0], 16'h0201, "R13", "commit with read");
        bus(0, 1, 2'd0, 8'h00, 48'h0000_0000_7788, "R13");
        chk(last_rd, 8'h77, "R13", "live high after collision");

        // R11 control port reads zero
        bus(0, 1, 2'd3, 8'h00, rnd48(), "R11");
        chk(last_rd, 8'h00, "R11", "control read");

        // random mix, all requirements through the model
        for (int i = 0; i < 3000; i++) begin
            int op;
            logic [7:0] b;
            logic [1:0] ch;
            op = $urandom_range(0, 9);
            b  = 8'($urandom());
            ch = 2'($urandom_range(0, 2));
            case (op)
                0, 1:    bus(1, 0, 2'd3, b, rnd48(), "R1");
                2:       bus(1, 0, 2'd3, {ch, 2'b00, b[3:0]}, rnd48(), "R6");
                3, 4:    bus(1, 0, ch, b, rnd48(), "R3");
                5, 6, 7: bus(0, 1, 2'($urandom_range(0, 3)), b, rnd48(), "R8");
                default: bus(1, 1, ch, b, rnd48(), "R13");
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule